// File: doc/BRIEF.md
# Buffered handshake increment stage

This block is one stage of a data pipeline. Both of its sides use a valid/ready handshake. A word crosses a side only in a clock cycle where that side's valid and ready are both high. Each accepted word is increased by one and appears at the output one clock after it was accepted. The sum wraps modulo 2^DATA_W.

The ready signal to the upstream side comes straight from a flop. Because of this, a word can still arrive in the cycle where the downstream side stalls. A one-entry spare register catches that word, so nothing is lost. Upstream ready stays low while the spare register is occupied.

Stages can be chained by wiring one stage's output valid, data and ready to the next stage's input side. Each stage in the chain adds one clock of latency and adds one to the data.

Top module: `incs_stage`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and in_ready is 1. Reset is synchronous and active high.
- R2: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged on the next cycle.
- R3: A word accepted while the output register is empty makes out_valid 1 on the very next cycle, not in the cycle of acceptance.
- R4: out_data equals the accepted in_data plus 1, modulo 2^DATA_W, so all-ones becomes zero.
- R5: A word accepted while the output is held (out_valid 1, out_ready 0) goes into the spare register, and in_ready is 0 on the next cycle. Whenever in_ready is 0, out_valid is 1.
- R6: Words leave in exactly the order they were accepted, with none dropped or repeated, under any mix of input gaps and output stalls.
- R7: When in_ready is 0 and the downstream side accepts, out_valid stays 1 with the spare word on the next cycle, and in_ready returns to 1 on that same cycle.
- R8: After out_ready returns, out_valid stays high until every held word has been delivered. It falls on the cycle after the last delivery, provided no new word was accepted.
- R9: Two chained stages give out_valid two clocks after acceptance, with data equal to the input plus 2.
- R10: A word presented on in_data with in_valid high while in_ready is 0 is not taken. It never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Stage can take a word (registered) |
| in_data | input | DATA_W | Upstream word |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DATA_W | Incremented word |

## Verification
The bench fills the spare register by stalling the output just as a second word arrives. A design without a working spare would lose that word or show it twice while draining. The bench then checks that out_valid does not fall early while the spare word is still waiting, and that in_ready comes back exactly one cycle after the spare drains. It drives junk words while in_ready is low, which a design that ignores its own ready would pass through. It checks the all-ones wrap, the one-cycle and two-cycle latencies, and a long run of random gaps and stalls compared against an in-order reference queue.

// File: rtl/incs_pkg.sv
package incs_pkg;
   // Next-state summary of the stage occupancy
   typedef struct packed {
      logic out_full;
      logic skid_full;
   } incs_occ_t;

   function automatic int unsigned incs_min_width();
      return 1;
   endfunction
endpackage

// File: rtl/incs_xform.sv
module incs_xform #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STEP   = 1
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

   generate
      if (STEP == 0) begin : g_pass
         assign dout = din;
      end else begin : g_add
         assign dout = din + STEP_V;
      end
   endgenerate
endmodule

// File: rtl/incs_hold.sv
module incs_hold #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (load) q <= d;
   end
endmodule

// File: rtl/incs_ctrl.sv
module incs_ctrl
   import incs_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic out_ready,
   output logic in_ready,
   output logic out_valid,
   output logic load_out,
   output logic sel_skid,
   output logic load_skid
);
   logic      skid_full;
   logic      acc;
   logic      adv;
   incs_occ_t nxt;

   always_comb begin
      acc       = in_valid & in_ready;
      adv       = ~out_valid | out_ready;
      load_out  = adv & (skid_full | acc);
      sel_skid  = skid_full;
      load_skid = ~adv & acc;
      if (adv) begin
         nxt.out_full  = skid_full | acc;
         nxt.skid_full = 1'b0;
      end else begin
         nxt.out_full  = 1'b1;
         nxt.skid_full = skid_full | acc;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         skid_full <= 1'b0;
         in_ready  <= 1'b1;
      end else begin
         out_valid <= nxt.out_full;
         skid_full <= nxt.skid_full;
         in_ready  <= ~nxt.skid_full;
      end
   end

   // R1: reset values seen on the first cycle after reset
   a_r1_reset_state: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && in_ready));

   // R3: acceptance into an empty stage shows valid one cycle later
   a_r3_latency: assert property (@(posedge clk) disable iff (rst)
      (acc && !out_valid) |=> out_valid);

   // R5: word caught while held closes the input
   a_r5_skid_closes: assert property (@(posedge clk) disable iff (rst)
      (acc && out_valid && !out_ready) |=> !in_ready);

   // R5: input can only be closed while the output holds a word
   a_r5_closed_valid: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> out_valid);

   // R7: spare word advances and input reopens
   a_r7_skid_drain: assert property (@(posedge clk) disable iff (rst)
      (!in_ready && out_ready) |=> (out_valid && in_ready));

   // R8: valid falls after the last delivery with nothing new
   a_r8_valid_falls: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && in_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/incs_stage.sv
module incs_stage
   import incs_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int unsigned STEP = 1;

   generate
      if (DATA_W < incs_min_width()) begin : g_bad_width
         $error("incs_stage: DATA_W must be at least 1");
      end
   endgenerate

   logic              load_out;
   logic              sel_skid;
   logic              load_skid;
   logic [DATA_W-1:0] inc_w;
   logic [DATA_W-1:0] skid_q;
   logic [DATA_W-1:0] out_d;

   incs_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .load_out  (load_out),
      .sel_skid  (sel_skid),
      .load_skid (load_skid)
   );

   incs_xform #(.DATA_W(DATA_W), .STEP(STEP)) u_xform (
      .din  (in_data),
      .dout (inc_w)
   );

   incs_hold #(.DATA_W(DATA_W)) u_skid (
      .clk  (clk),
      .load (load_skid),
      .d    (inc_w),
      .q    (skid_q)
   );

   assign out_d = sel_skid ? skid_q : inc_w;

   incs_hold #(.DATA_W(DATA_W)) u_out (
      .clk  (clk),
      .load (load_out),
      .d    (out_d),
      .q    (out_data)
   );

   // R2: held output keeps valid and data
   a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R4: word accepted into an empty stage appears incremented
   a_r4_increment: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && !out_valid) |=> (out_data == $past(in_data) + DATA_W'(STEP)));
endmodule

// File: tb/incs_stage_bench.sv
`timescale 1ns/1ps
module incs_stage_bench;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst;
   logic in_valid, out_ready, in_ready, out_valid;
   logic [W-1:0] in_data, out_data;

   logic ca_iv, ca_ir, ab_v, ab_r, cb_ov, cb_or;
   logic [W-1:0] ca_d, ab_d, cb_d;

   int errors = 0;
   int checks = 0;
   logic [W-1:0] q[$];

   always #2.5 clk = ~clk;

   incs_stage #(.DATA_W(W)) u_incs_stage (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data));

   incs_stage #(.DATA_W(W)) u_chain_a (
      .clk(clk), .rst(rst), .in_valid(ca_iv), .in_ready(ca_ir),
      .in_data(ca_d), .out_valid(ab_v), .out_ready(ab_r), .out_data(ab_d));

   incs_stage #(.DATA_W(W)) u_chain_b (
      .clk(clk), .rst(rst), .in_valid(ab_v), .in_ready(ab_r),
      .in_data(ab_d), .out_valid(cb_ov), .out_ready(cb_or), .out_data(cb_d));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // one cycle: drive, model handshakes, check any delivered word (R6)
   task automatic step(input logic iv, input logic [W-1:0] d, input logic ordy);
      in_valid  = iv;
      in_data   = d;
      out_ready = ordy;
      #0.5;
      if (out_valid && ordy) begin
         if (q.size() == 0) chk("R6 unexpected word", out_data, 'x);
         else chk("R6 order", out_data, q.pop_front());
      end
      if (iv && in_ready) q.push_back(d + 1);
      tick();
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 0; out_ready = 0; in_data = 0;
      ca_iv = 0; ca_d = 0; cb_or = 0;
      tick(); tick();
      chk("R1 out_valid in reset", {31'd0, out_valid}, 0);
      chk("R1 in_ready in reset", {31'd0, in_ready}, 1);
      rst = 1'b0;
      tick();
      chk("R1 out_valid after reset", {31'd0, out_valid}, 0);
      chk("R1 in_ready after reset", {31'd0, in_ready}, 1);
      q.delete();
   endtask

   task automatic t_latency();
      in_valid = 1; in_data = 32'd5; out_ready = 1;
      #0.5;
      chk("R3 valid not same cycle", {31'd0, out_valid}, 0);
      q.push_back(32'd6);
      tick();
      chk("R3 valid one cycle later", {31'd0, out_valid}, 1);
      chk("R4 data plus one", out_data, 32'd6);
      step(0, 0, 1);
      chk("R8 valid falls when empty", {31'd0, out_valid}, 0);
   endtask

   task automatic t_wrap();
      step(1, 32'hFFFF_FFFF, 1);
      chk("R4 wrap to zero", out_data, 32'd0);
      step(0, 0, 1);
   endtask

   task automatic t_stall_fill_drain();
      step(1, 32'd100, 0);
      chk("R3 first word valid", {31'd0, out_valid}, 1);
      step(1, 32'd200, 0);
      chk("R5 in_ready low when spare used", {31'd0, in_ready}, 0);
      step(0, 0, 0);
      chk("R2 data held under stall", out_data, 32'd101);
      // R10: junk while closed
      step(1, 32'hDEAD_0000, 0);
      step(1, 32'hDEAD_0001, 0);
      chk("R10 still closed", {31'd0, in_ready}, 0);
      step(0, 0, 1);
      chk("R7 valid stays with spare word", {31'd0, out_valid}, 1);
      chk("R7 in_ready back", {31'd0, in_ready}, 1);
      chk("R7 spare word at output", out_data, 32'd201);
      step(0, 0, 1);
      chk("R8 valid falls after last", {31'd0, out_valid}, 0);
      chk("R10 no junk left", q.size(), 0);
   endtask

   task automatic t_random();
      for (int i = 0; i < 2000; i++) begin
         logic iv, ordy;
         iv   = ($urandom % 3) != 0;
         ordy = ($urandom % 4) != 0;
         step(iv, $urandom, ordy);
      end
      for (int i = 0; i < 10; i++) step(0, 0, 1);
      chk("R6 all words delivered", q.size(), 0);
      chk("R8 valid low after drain", {31'd0, out_valid}, 0);
   endtask

   task automatic t_chain();
      cb_or = 1; ca_iv = 1; ca_d = 32'd40;
      tick();
      ca_iv = 0;
      chk("R9 not valid after one clock", {31'd0, cb_ov}, 0);
      tick();
      chk("R9 valid after two clocks", {31'd0, cb_ov}, 1);
      chk("R9 data plus two", cb_d, 32'd42);
      tick();
      chk("R9 valid clears", {31'd0, cb_ov}, 0);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_wrap();
      t_stall_fill_drain();
      t_random();
      t_chain();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule